// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receive Buffer

This block is the receive half of a single isochronous OUT endpoint in a full-speed USB device controller. The serial interface engine delivers each packet as a start strobe, a run of byte strobes and an end strobe. The block collects those bytes into a byte store sized for two maximum-size packets, with a small side queue that records the length of every accepted packet. A CPU drains the store through a one-byte-per-strobe read port and watches a 32-bit control/status word.

Storage is managed in whole packets. Bytes of a packet that is still arriving are written ahead of a committed pointer and stay invisible until the end strobe accepts them. A packet that runs out of room, grows beyond the maximum size, or finds the length queue full is rewound in full and flagged as an overflow. The status word reports whether a whole packet is held, whether any byte remains, whether a held packet is short, and two sticky events (packet accepted, packet discarded) that software clears by writing ones. An interrupt line follows the two sticky events.

Top module: `iso_rx_endpoint`

## Requirements
- R1: After reset the status word reads 0x00000000 and `irq` is 0.
- R2: Status bits 31..8 and 5..3 always read 0.
- R3: Status bit 0 reads 1 exactly while at least one fully accepted, not fully read packet is held.
- R4: Status bit 1 is set in the cycle after the end strobe of an accepted packet (1 to MAX_PKT bytes, room for all its bytes, length queue not full); writing 1 to bit 1 clears it.
- R5: A packet is discarded in full, with status bit 2 set in the cycle after its end strobe, when a byte arrives with the store full, when it carries more than MAX_PKT bytes, or when the length queue already holds LENQ packets; none of its bytes are ever readable; writing 1 to bit 2 clears it.
- R6: Status bit 6 reads 1 exactly while at least one byte of an accepted packet is unread; bytes of a packet still arriving do not count.
- R7: Status bit 7 reads 1 while any held packet is shorter than MAX_PKT bytes, and drops once the last byte of the last such packet has been read.
- R8: Writing 0 to bits 1 and 2, and writing any value to other bits, has no effect; a set event in the same cycle as a write-1 clear of that bit leaves it set.
- R9: `irq` is 1 exactly while status bit 1 or bit 2 is 1.
- R10: A read strobe presents, on `rd_data` in the next cycle, the oldest unread accepted byte, in arrival order; a read strobe with no readable byte returns 0 and moves nothing.
- R11: A start strobe during an unfinished packet abandons its bytes and begins a new packet; a start followed by an end with no bytes stores nothing and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sie_sop | input | 1 | Start of an incoming packet |
| sie_data_vld | input | 1 | A packet byte is present on `sie_data` |
| sie_data | input | 8 | Packet byte |
| sie_eop | input | 1 | End of the incoming packet (a byte in the same cycle is included) |
| rd_stb | input | 1 | CPU byte read strobe |
| rd_data | output | 8 | Byte returned by the previous read strobe |
| csr_wr | input | 1 | Status word write strobe |
| csr_wdata | input | 32 | Status word write value |
| csr_rdata | output | 32 | Status word read value |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions matter: the end strobe that accepts one packet landing in the same cycle as the CPU reading the last byte of the previous packet, and that same end strobe meeting a write-1 clear of the accepted-packet bit. The bench provokes both at once by raising the end strobe of a three-byte packet together with the read strobe for the final byte of an older two-byte packet and a clear write of bit 1. It then judges that the old byte is returned, the new packet counts as held and short while the old one no longer does, the accepted-packet bit stays set, and the new packet reads back intact.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;

    localparam int BIT_SVC   = 0;
    localparam int BIT_DONE  = 1;
    localparam int BIT_OVF   = 2;
    localparam int BIT_AVAIL = 6;
    localparam int BIT_SHORT = 7;

    typedef struct packed {
        logic short_held;
        logic bytes_left;
        logic overflow;
        logic done;
        logic pkt_held;
    } rx_status_t;

    function automatic logic [31:0] pack_status(rx_status_t s);
        logic [31:0] w;
        w            = '0;
        w[BIT_SVC]   = s.pkt_held;
        w[BIT_DONE]  = s.done;
        w[BIT_OVF]   = s.overflow;
        w[BIT_AVAIL] = s.bytes_left;
        w[BIT_SHORT] = s.short_held;
        return w;
    endfunction

endpackage

// File: rtl/iso_rx_store.sv
module iso_rx_store #(
    parameter int MAX_PKT = 256,
    parameter int DEPTH   = 512,
    parameter int LW      = $clog2(MAX_PKT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sie_sop,
    input  logic          sie_data_vld,
    input  logic [7:0]    sie_data,
    input  logic          sie_eop,
    input  logic          lenq_full,
    input  logic [LW-1:0] head_len,
    input  logic          rd_stb,
    output logic [7:0]    rd_data,
    output logic          commit,
    output logic [LW-1:0] commit_len,
    output logic          discard,
    output logic          pop,
    output logic          not_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [LW-1:0] MAX_L   = LW'(MAX_PKT);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wp_spec, wp_cmt, rp;
    logic [LW-1:0] cur_len, rd_idx;
    logic          in_pkt, dropping;

    logic [PW-1:0] fill, avail;
    logic          take, fits, wr_en, drop_now, eop_evt, rd_ok;
    logic [LW-1:0] len_final;

    always_comb begin
        fill       = wp_spec - rp;
        avail      = wp_cmt - rp;
        take       = in_pkt && !sie_sop && sie_data_vld;
        fits       = (fill < DEPTH_P) && (cur_len < MAX_L);
        wr_en      = take && fits && !dropping;
        drop_now   = dropping || (take && !fits);
        len_final  = cur_len + LW'(wr_en);
        eop_evt    = in_pkt && !sie_sop && sie_eop;
        commit     = eop_evt && !drop_now && (len_final != '0) && !lenq_full;
        discard    = eop_evt && (drop_now || ((len_final != '0) && lenq_full));
        commit_len = len_final;
        not_empty  = (avail != '0);
        rd_ok      = rd_stb && not_empty;
        pop        = rd_ok && ((rd_idx + LW'(1)) == head_len);
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp_spec[AW-1:0]] <= sie_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_spec  <= '0;
            wp_cmt   <= '0;
            cur_len  <= '0;
            in_pkt   <= 1'b0;
            dropping <= 1'b0;
        end else if (sie_sop) begin
            in_pkt   <= 1'b1;
            wp_spec  <= wp_cmt;
            cur_len  <= '0;
            dropping <= 1'b0;
        end else begin
            if (wr_en) begin
                wp_spec <= wp_spec + PW'(1);
                cur_len <= cur_len + LW'(1);
            end
            if (take && !fits) dropping <= 1'b1;
            if (eop_evt) begin
                in_pkt <= 1'b0;
                if (commit) wp_cmt  <= wp_spec + PW'(wr_en);
                else        wp_spec <= wp_cmt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rp      <= '0;
            rd_idx  <= '0;
            rd_data <= '0;
        end else if (rd_ok) begin
            rp      <= rp + PW'(1);
            rd_data <= mem[rp[AW-1:0]];
            rd_idx  <= pop ? '0 : rd_idx + LW'(1);
        end else if (rd_stb) begin
            rd_data <= '0;
        end
    end

endmodule

// File: rtl/iso_rx_lenq.sv
module iso_rx_lenq #(
    parameter int LW      = 9,
    parameter int ENTRIES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [LW-1:0] push_len,
    input  logic          pop,
    output logic [LW-1:0] head_len,
    output logic          held,
    output logic          full
);
    localparam int QW = $clog2(ENTRIES);
    localparam int PW = QW + 1;

    logic [LW-1:0] q [ENTRIES];
    logic [PW-1:0] wp, rp, cnt;

    always_comb begin
        cnt      = wp - rp;
        held     = (cnt != '0);
        full     = (cnt == PW'(ENTRIES));
        head_len = q[rp[QW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (push) q[wp[QW-1:0]] <= push_len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + PW'(1);
            if (pop && held) rp <= rp + PW'(1);
        end
    end

endmodule

// File: rtl/iso_rx_csr.sv
module iso_rx_csr
    import iso_rx_pkg::*;
#(
    parameter int MAX_PKT = 256,
    parameter int LW      = 9,
    parameter int ENTRIES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit,
    input  logic [LW-1:0] commit_len,
    input  logic          discard,
    input  logic          pop,
    input  logic [LW-1:0] head_len,
    input  logic          pkt_held,
    input  logic          bytes_left,
    input  logic          clr_done,
    input  logic          clr_ovf,
    output logic [31:0]   csr_rdata,
    output logic          irq
);
    localparam int SW = $clog2(ENTRIES + 1);
    localparam logic [LW-1:0] MAX_L = LW'(MAX_PKT);

    logic          done_q, ovf_q;
    logic [SW-1:0] short_cnt;
    logic          short_in, short_out;
    rx_status_t    st;

    always_comb begin
        short_in      = commit && (commit_len < MAX_L);
        short_out     = pop && (head_len < MAX_L);
        st.pkt_held   = pkt_held;
        st.done       = done_q;
        st.overflow   = ovf_q;
        st.bytes_left = bytes_left;
        st.short_held = (short_cnt != '0);
        csr_rdata     = pack_status(st);
        irq           = done_q || ovf_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q    <= 1'b0;
            ovf_q     <= 1'b0;
            short_cnt <= '0;
        end else begin
            done_q    <= commit  || (done_q && !clr_done);
            ovf_q     <= discard || (ovf_q && !clr_ovf);
            short_cnt <= short_cnt + SW'(short_in) - SW'(short_out);
        end
    end

endmodule

// File: rtl/iso_rx_endpoint.sv
module iso_rx_endpoint
    import iso_rx_pkg::*;
#(
    parameter int MAX_PKT = 256,
    parameter int LENQ    = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sie_sop,
    input  logic        sie_data_vld,
    input  logic [7:0]  sie_data,
    input  logic        sie_eop,
    input  logic        rd_stb,
    output logic [7:0]  rd_data,
    input  logic        csr_wr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        irq
);
    localparam int DEPTH = 2 * MAX_PKT;
    localparam int LW    = $clog2(MAX_PKT + 1);

    logic          commit_w, discard_w, pop_w, not_empty_w;
    logic          lenq_full_w, held_w;
    logic [LW-1:0] commit_len_w, head_len_w;
    logic          clr_done_w, clr_ovf_w;
    logic          unused_wbits;

    assign clr_done_w   = csr_wr && csr_wdata[BIT_DONE];
    assign clr_ovf_w    = csr_wr && csr_wdata[BIT_OVF];
    assign unused_wbits = ^{csr_wdata[31:3], csr_wdata[0]};

    iso_rx_store #(.MAX_PKT(MAX_PKT), .DEPTH(DEPTH), .LW(LW)) i_store (
        .clk, .rst,
        .sie_sop, .sie_data_vld, .sie_data, .sie_eop,
        .lenq_full (lenq_full_w),
        .head_len  (head_len_w),
        .rd_stb, .rd_data,
        .commit    (commit_w),
        .commit_len(commit_len_w),
        .discard   (discard_w),
        .pop       (pop_w),
        .not_empty (not_empty_w)
    );

    iso_rx_lenq #(.LW(LW), .ENTRIES(LENQ)) i_lenq (
        .clk, .rst,
        .push     (commit_w),
        .push_len (commit_len_w),
        .pop      (pop_w),
        .head_len (head_len_w),
        .held     (held_w),
        .full     (lenq_full_w)
    );

    iso_rx_csr #(.MAX_PKT(MAX_PKT), .LW(LW), .ENTRIES(LENQ)) i_csr (
        .clk, .rst,
        .commit    (commit_w),
        .commit_len(commit_len_w),
        .discard   (discard_w),
        .pop       (pop_w),
        .head_len  (head_len_w),
        .pkt_held  (held_w),
        .bytes_left(not_empty_w),
        .clr_done  (clr_done_w),
        .clr_ovf   (clr_ovf_w),
        .csr_rdata,
        .irq
    );

endmodule

// File: rtl/iso_rx_checker.sv
module iso_rx_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] csr_rdata,
    input logic        irq,
    input logic        rd_stb,
    input logic [7:0]  rd_data,
    input logic        commit,
    input logic        discard,
    input logic        clr_done
);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (csr_rdata[31:8] == '0) && (csr_rdata[5:3] == '0));

    a_r3_held_has_bytes: assert property (@(posedge clk) disable iff (rst)
        csr_rdata[0] |-> csr_rdata[6]);

    a_r7_short_is_held: assert property (@(posedge clk) disable iff (rst)
        csr_rdata[7] |-> csr_rdata[0]);

    a_r4_w1c_done: assert property (@(posedge clk) disable iff (rst)
        (clr_done && !commit) |=> !csr_rdata[1]);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        commit |=> csr_rdata[1]);

    a_r5_discard_flags: assert property (@(posedge clk) disable iff (rst)
        discard |=> csr_rdata[2]);

    a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(commit || discard));

    a_r10_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !csr_rdata[6]) |=> (rd_data == 8'h00));

endmodule

bind iso_rx_endpoint iso_rx_checker i_chk (
    .clk, .rst, .csr_rdata, .irq, .rd_stb, .rd_data,
    .commit  (commit_w),
    .discard (discard_w),
    .clr_done(clr_done_w)
);

// File: tb/test_iso_rx_endpoint.sv
module test_iso_rx_endpoint;
    localparam int MAXP = 8;
    localparam int LQ   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sie_sop = 0, sie_data_vld = 0, sie_eop = 0, rd_stb = 0, csr_wr = 0;
    logic [7:0]  sie_data = '0;
    logic [31:0] csr_wdata = '0;
    logic [7:0]  rd_data;
    logic [31:0] csr_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    iso_rx_endpoint #(.MAX_PKT(MAXP), .LENQ(LQ)) i_iso_rx_endpoint (
        .clk, .rst, .sie_sop, .sie_data_vld, .sie_data, .sie_eop,
        .rd_stb, .rd_data, .csr_wr, .csr_wdata, .csr_rdata, .irq
    );

    function automatic logic [7:0] dbyte(int p, int i);
        return 8'((p * 37) + (i * 11) + 5);
    endfunction

    function automatic logic [31:0] st(bit svc, bit done, bit ovf, bit ne, bit sh);
        logic [31:0] w = '0;
        w[0] = svc; w[1] = done; w[2] = ovf; w[6] = ne; w[7] = sh;
        return w;
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic csr_write(logic [31:0] v);
        csr_wr = 1; csr_wdata = v; tick(); csr_wr = 0; csr_wdata = '0;
    endtask

    task automatic send_bytes(int p, int n);
        for (int i = 0; i < n; i++) begin
            sie_data_vld = 1; sie_data = dbyte(p, i); tick();
        end
        sie_data_vld = 0;
    endtask

    task automatic send_pkt(int p, int n);
        sie_sop = 1; tick(); sie_sop = 0;
        send_bytes(p, n);
        sie_eop = 1; tick(); sie_eop = 0;
    endtask

    task automatic read_pkt(string tag, int p, int n);
        for (int i = 0; i < n; i++) begin
            rd_stb = 1; tick(); rd_stb = 0;
            chk(tag, {24'h0, rd_data}, {24'h0, dbyte(p, i)});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0; tick();
        chk("R1 reset csr", csr_rdata, 32'h0);
        chk("R1 reset irq", {31'h0, irq}, 32'h0);

        // sweep of every packet length
        for (int n = 1; n <= MAXP; n++) begin
            send_pkt(n, n);
            chk("R4 R3 R6 R7 R2 after accept", csr_rdata, st(1, 1, 0, 1, n < MAXP));
            chk("R9 irq on done", {31'h0, irq}, 32'h1);
            csr_write(32'hFFFF_FFF9);
            chk("R8 ro/zero write ignored", csr_rdata, st(1, 1, 0, 1, n < MAXP));
            csr_write(32'h2);
            chk("R4 w1c done", csr_rdata, st(1, 0, 0, 1, n < MAXP));
            chk("R9 irq low", {31'h0, irq}, 32'h0);
            read_pkt("R10 data order", n, n);
            chk("R3 R6 R7 drained", csr_rdata, 32'h0);
            rd_stb = 1; tick(); rd_stb = 0;
            chk("R10 empty read", {24'h0, rd_data}, 32'h0);
        end

        // partial packet invisible, restart, zero-length
        sie_sop = 1; tick(); sie_sop = 0;
        send_bytes(50, 3);
        chk("R6 arriving bytes hidden", csr_rdata, 32'h0);
        send_pkt(51, 2);
        chk("R11 restart accepted", csr_rdata, st(1, 1, 0, 1, 1));
        read_pkt("R11 restart data", 51, 2);
        csr_write(32'h6);
        send_pkt(52, 0);
        chk("R11 zero length no flag", csr_rdata, 32'h0);

        // short flag with mixed lengths
        send_pkt(60, MAXP);
        send_pkt(61, 3);
        csr_write(32'h6);
        chk("R7 short held", csr_rdata, st(1, 0, 0, 1, 1));
        read_pkt("R10 full then short", 60, MAXP);
        chk("R7 short still held", csr_rdata, st(1, 0, 0, 1, 1));
        read_pkt("R10 short data", 61, 3);
        chk("R7 short cleared", csr_rdata, 32'h0);

        // store full drop
        send_pkt(70, MAXP);
        send_pkt(71, MAXP);
        csr_write(32'h6);
        send_pkt(72, 1);
        chk("R5 drop on full store", csr_rdata, st(1, 0, 1, 1, 0));
        chk("R9 irq on ovf", {31'h0, irq}, 32'h1);
        csr_write(32'h4);
        chk("R5 w1c ovf", csr_rdata, st(1, 0, 0, 1, 0));
        read_pkt("R5 kept packets intact", 70, MAXP);
        read_pkt("R5 kept packets intact", 71, MAXP);
        chk("R5 dropped bytes absent", csr_rdata, 32'h0);

        // oversize drop
        send_pkt(80, MAXP + 1);
        chk("R5 oversize dropped", csr_rdata, st(0, 0, 1, 0, 0));
        csr_write(32'h4);

        // length queue full drop
        for (int k = 0; k < LQ + 1; k++) send_pkt(90 + k, 1);
        chk("R5 length queue full", csr_rdata, st(1, 1, 1, 1, 1));
        csr_write(32'h6);
        for (int k = 0; k < LQ; k++) read_pkt("R5 queued singles", 90 + k, 1);
        chk("R5 fifth absent", csr_rdata, 32'h0);

        // accept + pop + clear in one cycle
        send_pkt(100, 2);
        csr_write(32'h6);
        read_pkt("R10 first byte", 100, 1);
        sie_sop = 1; tick(); sie_sop = 0;
        send_bytes(101, 3);
        sie_eop = 1; rd_stb = 1; csr_wr = 1; csr_wdata = 32'h2;
        tick();
        sie_eop = 0; rd_stb = 0; csr_wr = 0; csr_wdata = '0;
        chk("R10 last byte in collision", {24'h0, rd_data}, {24'h0, dbyte(100, 1)});
        chk("R8 set wins over clear", csr_rdata, st(1, 1, 0, 1, 1));
        read_pkt("R3 new packet data", 101, 3);
        chk("R7 R3 after collision", csr_rdata, st(0, 1, 0, 0, 0));

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule